// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block expands one scalar instruction into a run of scalar element operations. Each operand register (destination and two sources) carries a tag saying whether it is treated as a vector. The sequencer walks element indices from zero up to the vector length and emits one scalar micro-operation per element whose predicate bit is set. A tagged operand's register number is its base plus the element index; an untagged operand stays at its base register. The same operation therefore covers scalar-scalar, scalar-vector and vector-vector mixes without any extra opcode.

Micro-operations leave through a valid/ready port. While the loop runs the block holds the program counter. When it finishes it raises a one-cycle completion pulse. Masked-off elements cost no cycles: the sequencer jumps straight to the next set predicate bit. If an active element would name a register past the last one, the loop stops with an error pulse.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the block is idle: `start_ready` is 1 and `pc_hold`, `uop_valid`, `done` and `err` are all 0.
- R2: Active elements are issued in strictly ascending index order, each exactly once, and only indices below the vector length `vl` are considered. A `vl` above `MAX_VL` acts as `MAX_VL`.
- R3: Element i is issued only when bit i of `pred` is 1, with bit 0 belonging to element 0. An element whose bit is 0 produces no micro-operation.
- R4: For element i, each register output equals its base register plus i when that operand's tag is 1, and equals the base register when the tag is 0. Tag bits are `vtag[0]` for the destination, `vtag[1]` for source 1 and `vtag[2]` for source 2. Because the offset is the element index, masked-off elements still advance it.
- R5: Every micro-operation carries the captured operation code unchanged, for every tag mix.
- R6: A micro-operation transfers only in a cycle where `uop_valid` and `uop_ready` are both 1. While `uop_ready` is 0, the index, the registers and the operation stay unchanged.
- R7: `pc_hold` is 1 from the cycle after acceptance until the loop ends. It falls on the same edge that raises `done`.
- R8: With `vl` 0, or with no predicate bit set below `vl`, no micro-operation is issued and `done` is 1 in the second cycle after the accepting edge.
- R9: When an active element would map any register above `NREGS`-1, no micro-operation is issued for it and the loop ends. `err` and `done` pulse together in that cycle, and earlier elements are issued normally.
- R10: `done` lasts exactly one cycle. A start is taken only while `start_ready` is 1. A start presented while busy is ignored and does not disturb the running loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | New tagged instruction present |
| start_ready | output | 1 | Sequencer idle, instruction accepted |
| op_in | input | OP_W | Decoded scalar operation |
| rd_in | input | REG_W | Destination base register |
| rs1_in | input | REG_W | Source 1 base register |
| rs2_in | input | REG_W | Source 2 base register |
| vtag | input | 3 | Vector tags: [0] dest, [1] src1, [2] src2 |
| vl | input | VL_W | Vector length |
| pred | input | MAX_VL | Predicate mask, bit i gates element i |
| uop_valid | output | 1 | Micro-operation present |
| uop_ready | input | 1 | Downstream accepts micro-operation |
| uop_op | output | OP_W | Operation of the micro-operation |
| uop_rd | output | REG_W | Element destination register |
| uop_rs1 | output | REG_W | Element source 1 register |
| uop_rs2 | output | REG_W | Element source 2 register |
| uop_idx | output | IDX_W | Element index |
| pc_hold | output | 1 | Program counter must not advance |
| done | output | 1 | One-cycle loop completion pulse |
| err | output | 1 | One-cycle register-range error pulse |

## Verification
The bench builds the block with `MAX_VL` = 8 and 32 registers. This makes it practical to sweep every predicate pattern for every vector length from 0 to 8, with tag mixes and base registers varied across the sweep and a throttled ready on part of the runs. Expected issue lists, register numbers, completion timing and error points are computed arithmetically in the bench. Directed runs add register overflow at different elements and a start presented while the block is busy.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    localparam int NUM_OPND = 3;
    localparam int OPND_RD  = 0;
    localparam int OPND_RS1 = 1;
    localparam int OPND_RS2 = 2;

endpackage

// File: rtl/vseq_find_next.sv
module vseq_find_next #(
    parameter int W  = 8,
    parameter int FW = 4,
    parameter int IW = 3
) (
    input  logic [W-1:0]  mask,
    input  logic [FW-1:0] from,
    output logic          found,
    output logic [IW-1:0] pos
);

    // lowest set bit of mask at or above position from
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i] && (FW'(i) >= from)) begin
                found = 1'b1;
                pos   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vseq_reg_map.sv
module vseq_reg_map #(
    parameter int NREGS = 32,
    parameter int REG_W = 5,
    parameter int IDX_W = 3
) (
    input  logic [REG_W-1:0] base,
    input  logic             tag,
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] reg_num,
    output logic             oor
);

    localparam int SUM_W = ((REG_W > IDX_W) ? REG_W : IDX_W) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = SUM_W'(base) + (tag ? SUM_W'(idx) : '0);
        oor     = (sum > SUM_W'(NREGS - 1));
        reg_num = sum[REG_W-1:0];
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int MAX_VL = 64,
    parameter int OP_W   = 8,
    localparam int REG_W = $clog2(NREGS),
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [OP_W-1:0]   op_in,
    input  logic [REG_W-1:0]  rd_in,
    input  logic [REG_W-1:0]  rs1_in,
    input  logic [REG_W-1:0]  rs2_in,
    input  logic [2:0]        vtag,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAX_VL-1:0] pred,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [OP_W-1:0]   uop_op,
    output logic [REG_W-1:0]  uop_rd,
    output logic [REG_W-1:0]  uop_rs1,
    output logic [REG_W-1:0]  uop_rs2,
    output logic [IDX_W-1:0]  uop_idx,
    output logic              pc_hold,
    output logic              done,
    output logic              err
);

    typedef struct packed {
        seq_state_e                        st;
        logic [OP_W-1:0]                   op;
        logic [NUM_OPND-1:0][REG_W-1:0]    base;
        logic [NUM_OPND-1:0]               tag;
        logic [MAX_VL-1:0]                 mask;
        logic [IDX_W-1:0]                  idx;
        logic                              live;
        logic                              done;
        logic                              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [MAX_VL-1:0]               len_mask;
    logic [MAX_VL-1:0]               fn_mask;
    logic [VL_W-1:0]                 fn_from;
    logic                            fn_found;
    logic [IDX_W-1:0]                fn_pos;
    logic [NUM_OPND-1:0][REG_W-1:0]  map_reg;
    logic [NUM_OPND-1:0]             map_oor;
    logic                            any_oor;
    logic                            idle;

    assign idle = (seq_q.st == SQ_IDLE);

    // element indices below the vector length
    always_comb begin
        for (int i = 0; i < MAX_VL; i++) begin
            len_mask[i] = (VL_W'(i) < vl);
        end
    end

    // one search unit: first active element when idle, next one when running
    always_comb begin
        if (idle) begin
            fn_mask = pred & len_mask;
            fn_from = '0;
        end else begin
            fn_mask = seq_q.mask;
            fn_from = VL_W'(seq_q.idx) + VL_W'(1);
        end
    end

    vseq_find_next #(
        .W  (MAX_VL),
        .FW (VL_W),
        .IW (IDX_W)
    ) u_find (
        .mask  (fn_mask),
        .from  (fn_from),
        .found (fn_found),
        .pos   (fn_pos)
    );

    generate
        for (genvar g = 0; g < NUM_OPND; g++) begin : g_map
            vseq_reg_map #(
                .NREGS (NREGS),
                .REG_W (REG_W),
                .IDX_W (IDX_W)
            ) u_map (
                .base    (seq_q.base[g]),
                .tag     (seq_q.tag[g]),
                .idx     (seq_q.idx),
                .reg_num (map_reg[g]),
                .oor     (map_oor[g])
            );
        end
    endgenerate

    assign any_oor = |map_oor;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start_valid) begin
                    seq_d.st             = SQ_RUN;
                    seq_d.op             = op_in;
                    seq_d.base[OPND_RD]  = rd_in;
                    seq_d.base[OPND_RS1] = rs1_in;
                    seq_d.base[OPND_RS2] = rs2_in;
                    seq_d.tag            = vtag;
                    seq_d.mask           = fn_mask;
                    seq_d.live           = fn_found;
                    seq_d.idx            = fn_pos;
                end
            end
            SQ_RUN: begin
                if (!seq_q.live) begin
                    seq_d.st   = SQ_IDLE;
                    seq_d.done = 1'b1;
                end else if (any_oor) begin
                    seq_d.st   = SQ_IDLE;
                    seq_d.live = 1'b0;
                    seq_d.done = 1'b1;
                    seq_d.err  = 1'b1;
                end else if (uop_ready) begin
                    if (fn_found) begin
                        seq_d.idx = fn_pos;
                    end else begin
                        seq_d.st   = SQ_IDLE;
                        seq_d.live = 1'b0;
                        seq_d.done = 1'b1;
                    end
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign start_ready = idle;
    assign pc_hold     = (seq_q.st == SQ_RUN);
    assign uop_valid   = pc_hold && seq_q.live && !any_oor;
    assign uop_op      = seq_q.op;
    assign uop_rd      = map_reg[OPND_RD];
    assign uop_rs1     = map_reg[OPND_RS1];
    assign uop_rs2     = map_reg[OPND_RS2];
    assign uop_idx     = seq_q.idx;
    assign done        = seq_q.done;
    assign err         = seq_q.err;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_idx) && $stable(uop_rd)
            && $stable(uop_rs1) && $stable(uop_rs2) && $stable(uop_op)); // R6

    AST_ISSUE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready |=> !uop_valid || (uop_idx > $past(uop_idx))); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pc_hold && !uop_valid); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9

    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !uop_valid); // R10

endmodule

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;

    localparam int NREGS  = 32;
    localparam int MAX_VL = 8;
    localparam int OP_W   = 8;
    localparam int REG_W  = 5;
    localparam int IDX_W  = 3;
    localparam int VL_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic              start_ready;
    logic [OP_W-1:0]   op_in = '0;
    logic [REG_W-1:0]  rd_in = '0, rs1_in = '0, rs2_in = '0;
    logic [2:0]        vtag = '0;
    logic [VL_W-1:0]   vl = '0;
    logic [MAX_VL-1:0] pred = '0;
    logic              uop_valid;
    logic              uop_ready = 1'b0;
    logic [OP_W-1:0]   uop_op;
    logic [REG_W-1:0]  uop_rd, uop_rs1, uop_rs2;
    logic [IDX_W-1:0]  uop_idx;
    logic              pc_hold, done, err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    vec_elem_seq #(.NREGS(NREGS), .MAX_VL(MAX_VL), .OP_W(OP_W)) u_vec_elem_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .op_in(op_in), .rd_in(rd_in), .rs1_in(rs1_in), .rs2_in(rs2_in), .vtag(vtag),
        .vl(vl), .pred(pred), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_op(uop_op), .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2),
        .uop_idx(uop_idx), .pc_hold(pc_hold), .done(done), .err(err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int len, input int pm, input int tg, input int brd,
                            input int brs1, input int brs2, input int opc, input bit thr);
        int act[MAX_VL];
        int n_exp = 0;
        bit exp_err = 1'b0;
        int k = 0;
        int iter = 0;
        bit fin = 1'b0;
        int lim = (len > MAX_VL) ? MAX_VL : len;
        for (int i = 0; i < lim; i++) begin
            if (((pm >> i) & 1) == 1 && !exp_err) begin
                int r0 = brd  + (((tg >> 0) & 1) == 1 ? i : 0);
                int r1 = brs1 + (((tg >> 1) & 1) == 1 ? i : 0);
                int r2 = brs2 + (((tg >> 2) & 1) == 1 ? i : 0);
                if (r0 > NREGS - 1 || r1 > NREGS - 1 || r2 > NREGS - 1) exp_err = 1'b1;
                else begin act[n_exp] = i; n_exp++; end
            end
        end
        @(negedge clk);
        start_valid = 1'b1;
        op_in  = OP_W'(opc);
        rd_in  = REG_W'(brd);
        rs1_in = REG_W'(brs1);
        rs2_in = REG_W'(brs2);
        vtag   = 3'(tg);
        vl     = VL_W'(len);
        pred   = MAX_VL'(pm);
        @(posedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        while (!fin && iter < 100) begin
            iter++;
            if (done) begin
                chk(pc_hold == 1'b0, "R7 pc_hold at done", int'(pc_hold), 0);
                chk(k == n_exp, "R2 issued count", k, n_exp);
                chk(err == exp_err, "R9 err", int'(err), int'(exp_err));
                if (n_exp == 0 && !exp_err)
                    chk(iter == 2, "R8 empty completion cycle", iter, 2);
                fin = 1'b1;
            end else begin
                chk(pc_hold == 1'b1, "R7 pc_hold in loop", int'(pc_hold), 1);
                if (uop_valid) begin
                    chk(k < n_exp, "R3 unexpected uop", k, n_exp);
                    if (k < n_exp) begin
                        int i = act[k];
                        chk(int'(uop_idx) == i, "R3 element index", int'(uop_idx), i);
                        chk(int'(uop_rd) == brd + (((tg >> 0) & 1) == 1 ? i : 0),
                            "R4 rd", int'(uop_rd), brd + (((tg >> 0) & 1) == 1 ? i : 0));
                        chk(int'(uop_rs1) == brs1 + (((tg >> 1) & 1) == 1 ? i : 0),
                            "R4 rs1", int'(uop_rs1), brs1 + (((tg >> 1) & 1) == 1 ? i : 0));
                        chk(int'(uop_rs2) == brs2 + (((tg >> 2) & 1) == 1 ? i : 0),
                            "R4 rs2", int'(uop_rs2), brs2 + (((tg >> 2) & 1) == 1 ? i : 0));
                        chk(int'(uop_op) == opc, "R5 op", int'(uop_op), opc);
                    end
                end
            end
            uop_ready = thr ? ((cyc % 3) != 0) : 1'b1;
            if (!fin && uop_valid && uop_ready) k++;
            @(negedge clk);
        end
        chk(fin, "R2 loop end", int'(fin), 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(start_ready == 1'b1, "R1 start_ready", int'(start_ready), 1);
        chk(pc_hold == 1'b0, "R1 pc_hold", int'(pc_hold), 0);
        chk(uop_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1 outputs", int'(uop_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready == 1'b1, "R1 idle after release", int'(start_ready), 1);

        // R2 R3 R4 R5 R6 R8: full predicate sweep per vector length
        for (int len = 0; len <= MAX_VL; len++) begin
            for (int pm = 0; pm < 256; pm++) begin
                run_case(len, pm, (pm ^ len) & 7, len, 8 + (pm % 8), 16 + len,
                         pm, ((pm >> 1) & 1) == 1);
            end
        end
        // R2: oversized length behaves as MAX_VL
        run_case(12, 8'hA5, 7, 0, 1, 2, 8'h33, 1'b0);
        // R9: source 2 overflow at element 4
        run_case(8, 8'hFF, 4, 0, 0, 28, 8'h11, 1'b0);
        // R9: masked elements past the limit raise nothing
        run_case(8, 8'h01, 1, 30, 0, 0, 8'h12, 1'b1);
        // R9: destination overflow at element 2
        run_case(8, 8'h05, 1, 31, 0, 0, 8'h13, 1'b0);

        // R10: a start while busy is ignored
        @(negedge clk);
        uop_ready = 1'b0;
        start_valid = 1'b1; op_in = 8'hA5; rd_in = 5'd1; rs1_in = 5'd2; rs2_in = 5'd3;
        vtag = 3'b000; vl = 4'd8; pred = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        op_in = 8'h5A; vl = 4'd1;
        for (int c = 0; c < 4; c++) begin
            chk(start_ready == 1'b0, "R10 busy start_ready", int'(start_ready), 0);
            chk(int'(uop_op) == 8'hA5, "R10 op kept while busy", int'(uop_op), 8'hA5);
            chk(uop_idx == 3'd0, "R6 idx held while stalled", int'(uop_idx), 0);
            @(negedge clk);
        end
        start_valid = 1'b0;
        uop_ready = 1'b1;
        begin
            int n = 0;
            int guard = 0;
            while (!done && guard < 50) begin
                if (uop_valid) n++;
                guard++;
                @(negedge clk);
            end
            chk(n == 8, "R10 busy run issued", n, 8);
        end
        @(negedge clk);
        chk(start_ready == 1'b1, "R10 idle again", int'(start_ready), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule